// File: doc/BRIEF.md
# DMA bus-master transfer sequencer

This block is the control state machine of a multi-channel DMA controller. It waits in a quiet idle state while a processor programs the controller's configuration. When a channel raises a request that is not masked, the sequencer asks the host for the bus and then holds that request until the host grants the bus. Once the bus is granted, it runs one transfer cycle and then either goes back to wait for the bus again or returns to idle.

At the grant the block picks one of two paths. The I/O path is a single state. It drives the channel's memory address and acknowledges the winning channel with one strobe. The memory-to-memory path is a fixed run of eight states. In the first four it reads a byte from the source address into a holding register. In the last four it writes that byte to the destination address. The path is chosen by one of two rules, and the rule depends on the controller mode. An active-low end-of-process input never cuts a running cycle short. It only stops the service once that cycle has completed. Address and count arithmetic stays outside the block: the sequencer only pulses a step output and a decrement output.

In compatibility mode a software reset input acts like the hardware reset.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, and whenever the machine is idle, the outputs are inactive: bus_req=0, aen=0, addr=0, mem_rd_n=1, mem_wr_n=1, dack=0, addr_step=0, cnt_dec=0. Also cfg_open=1.
- R2: In idle, a channel whose chan_req bit is 1 and whose chan_mask bit is 0 makes bus_req go high at the next clock edge. Requests whose mask bit is 1 leave the machine idle.
- R3: In the acquire state, bus_req stays high and no other bus output is driven until bus_ack is sampled high while a request is pending. cfg_open is 1 in idle and acquire and 0 in every transfer state.
- R4: If no unmasked request is pending at an edge in the acquire state, the machine returns to idle even when bus_ack is high.
- R5: At the grant, the memory-to-memory path is chosen as follows. With compat_mode=1 it is chosen when cmd_m2m_en=1, chan_req[0]=1, chan_mask[0]=0 and win_ch=0. With compat_mode=0 it is chosen when act_m2m=1. In every other case the I/O path is taken.
- R6: The I/O path lasts one cycle. In it bus_req=1, aen=1, addr=io_addr, and dack is one-hot at the win_ch index latched at the grant. mem_wr_n is low when io_to_mem=1; otherwise mem_rd_n is low. addr_step and cnt_dec are both 1.
- R7: In memory-to-memory states 1 to 4, aen=1 and addr is the source address: ch0_addr when compat_mode=1, src_addr when compat_mode=0. dack=0 in all eight states. mem_rd_n is low in states 2 and 3 only. rd_data is captured at the end of state 3.
- R8: In states 5 to 8, addr=dst_addr and wr_data shows the captured byte. mem_wr_n is low in states 6 and 7 only. addr_step and cnt_dec are 1 in state 8 only.
- R9: After the I/O state or state 8, the machine goes to acquire when a request is pending, tc=0 and no end-of-process was seen. Otherwise it goes to idle.
- R10: eop_n low in any transfer state does not shorten the cycle. All eight memory-to-memory states still run, and then the machine goes idle.
- R11: sw_reset=1 with compat_mode=1 forces idle at the next edge and clears the holding register. With compat_mode=0, sw_reset is ignored.
- R12: mem_rd_n and mem_wr_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset, honoured only in compatibility mode |
| compat_mode | input | 1 | 1 = compatibility mode, 0 = native mode |
| chan_req | input | NCH | Channel requests |
| chan_mask | input | NCH | Per-channel mask, 1 = masked |
| win_ch | input | log2(NCH) | Channel index from the priority encoder |
| cmd_m2m_en | input | 1 | Memory-transfer enable from the command register |
| act_m2m | input | 1 | Memory-to-memory bit of the active channel's mode |
| io_to_mem | input | 1 | I/O path direction, 1 = write memory |
| bus_ack | input | 1 | Bus grant from the host |
| eop_n | input | 1 | Active-low end-of-process |
| tc | input | 1 | Terminal count from the count register |
| io_addr | input | AW | Active channel's current address |
| ch0_addr | input | AW | Channel 0 current address (compatibility source) |
| src_addr | input | AW | Source address (native mode) |
| dst_addr | input | AW | Destination address |
| rd_data | input | DW | Memory read data |
| bus_req | output | 1 | Bus request to the host |
| cfg_open | output | 1 | Configuration may be written |
| aen | output | 1 | Address enable |
| addr | output | AW | Address bus |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| dack | output | NCH | One-hot channel acknowledge |
| addr_step | output | 1 | Address update pulse |
| cnt_dec | output | 1 | Count decrement pulse |
| wr_data | output | DW | Holding register contents |

## Verification
Every output is decoded from the state register. So a request, grant, end-of-process or software reset sampled at a rising edge shows on the ports in the half cycle after that edge. A byte read in state 3 shows on wr_data from state 4 onward. The bench drives inputs just after each rising edge and advances its behavioural model at the same edge the design uses. It compares every output at the falling edge, when each of these results is due. The directed checks count falling edges from the stimulus edge in the same way. For example, the eight-state run with end-of-process held low is checked one state at a time, and then idle is checked at the ninth edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_ACQ  = 4'd1,
    ST_IO   = 4'd2,
    ST_M1   = 4'd3,
    ST_M2   = 4'd4,
    ST_M3   = 4'd5,
    ST_M4   = 4'd6,
    ST_M5   = 4'd7,
    ST_M6   = 4'd8,
    ST_M7   = 4'd9,
    ST_M8   = 4'd10
  } seq_state_t;

  function automatic logic is_m2m(seq_state_t s);
    return (s >= ST_M1) && (s <= ST_M8);
  endfunction

  function automatic logic m2m_rule(logic compat, logic cmd_en, logic req0,
                                    logic win_is0, logic mode_bit);
    return compat ? (cmd_en & req0 & win_is0) : mode_bit;
  endfunction

  function automatic logic stop_rule(logic tc, logic eop_seen, logic eop_n);
    return tc | eop_seen | ~eop_n;
  endfunction

  function automatic seq_state_t next_m2m(seq_state_t s);
    return seq_state_t'(4'(s) + 4'd1);
  endfunction

endpackage

// File: rtl/dma_path_pick.sv
module dma_path_pick #(
  parameter int CW = 2
) (
  input  logic          compat_mode,
  input  logic          cmd_m2m_en,
  input  logic          req0_live,
  input  logic [CW-1:0] win_ch,
  input  logic          act_m2m,
  output logic          m2m_sel
);
  import dma_seq_pkg::*;

  logic win_is0;
  assign win_is0 = (win_ch == '0);
  assign m2m_sel = m2m_rule(compat_mode, cmd_m2m_en, req0_live, win_is0, act_m2m);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm #(
  parameter int CW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      kill,
  input  logic                      pend,
  input  logic                      bus_ack,
  input  logic                      m2m_sel,
  input  logic                      eop_n,
  input  logic                      tc,
  input  logic [CW-1:0]             win_ch,
  output dma_seq_pkg::seq_state_t   state,
  output logic [CW-1:0]             act_ch
);
  import dma_seq_pkg::*;

  seq_state_t nxt;
  logic       eop_seen;
  logic       grant_evt;
  logic       cycle_end;
  logic       in_xfer;
  logic       halt;

  assign grant_evt = (state == ST_ACQ) && pend && bus_ack;
  assign cycle_end = (state == ST_IO) || (state == ST_M8);
  assign in_xfer   = (state == ST_IO) || is_m2m(state);
  assign halt      = stop_rule(tc, eop_seen, eop_n);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (pend) nxt = ST_ACQ;
      ST_ACQ: begin
        if (!pend)        nxt = ST_IDLE;
        else if (bus_ack) nxt = m2m_sel ? ST_M1 : ST_IO;
      end
      ST_IO, ST_M8: nxt = (pend && !halt) ? ST_ACQ : ST_IDLE;
      ST_M1, ST_M2, ST_M3, ST_M4, ST_M5, ST_M6, ST_M7: nxt = next_m2m(state);
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      eop_seen <= 1'b0;
      act_ch   <= '0;
    end else if (kill) begin
      state    <= ST_IDLE;
      eop_seen <= 1'b0;
      act_ch   <= '0;
    end else begin
      state <= nxt;
      if (cycle_end)              eop_seen <= 1'b0;
      else if (in_xfer && !eop_n) eop_seen <= 1'b1;
      if (grant_evt) act_ch <= win_ch;
    end
  end

  AST_ACQ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && pend && !bus_ack && !kill) |=> (state == ST_ACQ)); // R3

  AST_ACQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && !pend && !kill) |=> (state == ST_IDLE)); // R4

  AST_M2M_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_m2m(state) && state != ST_M8 && !kill) |=> (4'(state) == 4'($past(state)) + 4'd1)); // R10

  AST_EOP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && (eop_seen || !eop_n) && !kill) |=> (state == ST_IDLE)); // R10

  AST_SOFT_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/dma_seq_drive.sv
module dma_seq_drive #(
  parameter int NCH = 4,
  parameter int CW  = 2,
  parameter int AW  = 16,
  parameter int DW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     kill,
  input  dma_seq_pkg::seq_state_t  state,
  input  logic [CW-1:0]            act_ch,
  input  logic                     compat_mode,
  input  logic                     io_to_mem,
  input  logic [AW-1:0]            io_addr,
  input  logic [AW-1:0]            ch0_addr,
  input  logic [AW-1:0]            src_addr,
  input  logic [AW-1:0]            dst_addr,
  input  logic [DW-1:0]            rd_data,
  output logic                     bus_req,
  output logic                     cfg_open,
  output logic                     aen,
  output logic [AW-1:0]            addr,
  output logic                     mem_rd_n,
  output logic                     mem_wr_n,
  output logic [NCH-1:0]           dack,
  output logic                     addr_step,
  output logic                     cnt_dec,
  output logic [DW-1:0]            wr_data
);
  import dma_seq_pkg::*;

  logic [AW-1:0] src_pick;
  logic          xfer_pulse;
  logic          capture;

  assign src_pick = compat_mode ? ch0_addr : src_addr;
  assign capture  = (state == ST_M3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_data <= '0;
    else if (kill)    wr_data <= '0;
    else if (capture) wr_data <= rd_data;
  end

  always_comb begin
    bus_req    = (state != ST_IDLE);
    cfg_open   = (state == ST_IDLE) || (state == ST_ACQ);
    aen        = 1'b0;
    addr       = '0;
    mem_rd_n   = 1'b1;
    mem_wr_n   = 1'b1;
    dack       = '0;
    xfer_pulse = 1'b0;
    case (state)
      ST_IO: begin
        aen        = 1'b1;
        addr       = io_addr;
        dack       = NCH'(1) << act_ch;
        mem_wr_n   = !io_to_mem;
        mem_rd_n   = io_to_mem;
        xfer_pulse = 1'b1;
      end
      ST_M1, ST_M4: begin aen = 1'b1; addr = src_pick; end
      ST_M2, ST_M3: begin aen = 1'b1; addr = src_pick; mem_rd_n = 1'b0; end
      ST_M5:        begin aen = 1'b1; addr = dst_addr; end
      ST_M6, ST_M7: begin aen = 1'b1; addr = dst_addr; mem_wr_n = 1'b0; end
      ST_M8:        begin aen = 1'b1; addr = dst_addr; xfer_pulse = 1'b1; end
      default: ;
    endcase
  end

  assign addr_step = xfer_pulse;
  assign cnt_dec   = xfer_pulse;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!aen && mem_rd_n && mem_wr_n && dack == '0 && !addr_step)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R12

  AST_M2M_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    is_m2m(state) |-> (dack == '0)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> !addr_step); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_M6 && !kill) |=> $stable(wr_data)); // R8

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_reset,
  input  logic                     compat_mode,
  input  logic [NCH-1:0]           chan_req,
  input  logic [NCH-1:0]           chan_mask,
  input  logic [$clog2(NCH)-1:0]   win_ch,
  input  logic                     cmd_m2m_en,
  input  logic                     act_m2m,
  input  logic                     io_to_mem,
  input  logic                     bus_ack,
  input  logic                     eop_n,
  input  logic                     tc,
  input  logic [AW-1:0]            io_addr,
  input  logic [AW-1:0]            ch0_addr,
  input  logic [AW-1:0]            src_addr,
  input  logic [AW-1:0]            dst_addr,
  input  logic [DW-1:0]            rd_data,
  output logic                     bus_req,
  output logic                     cfg_open,
  output logic                     aen,
  output logic [AW-1:0]            addr,
  output logic                     mem_rd_n,
  output logic                     mem_wr_n,
  output logic [NCH-1:0]           dack,
  output logic                     addr_step,
  output logic                     cnt_dec,
  output logic [DW-1:0]            wr_data
);
  import dma_seq_pkg::*;

  localparam int CW = $clog2(NCH);

  logic [NCH-1:0] live_req;
  logic           pend;
  logic           kill;
  logic           m2m_sel;
  seq_state_t     state;
  logic [CW-1:0]  act_ch;

  assign live_req = chan_req & ~chan_mask;
  assign pend     = |live_req;
  assign kill     = sw_reset && compat_mode;

  dma_path_pick #(.CW(CW)) u_pick (
    .compat_mode (compat_mode),
    .cmd_m2m_en  (cmd_m2m_en),
    .req0_live   (live_req[0]),
    .win_ch      (win_ch),
    .act_m2m     (act_m2m),
    .m2m_sel     (m2m_sel)
  );

  dma_seq_fsm #(.CW(CW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (kill),
    .pend    (pend),
    .bus_ack (bus_ack),
    .m2m_sel (m2m_sel),
    .eop_n   (eop_n),
    .tc      (tc),
    .win_ch  (win_ch),
    .state   (state),
    .act_ch  (act_ch)
  );

  dma_seq_drive #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .kill        (kill),
    .state       (state),
    .act_ch      (act_ch),
    .compat_mode (compat_mode),
    .io_to_mem   (io_to_mem),
    .io_addr     (io_addr),
    .ch0_addr    (ch0_addr),
    .src_addr    (src_addr),
    .dst_addr    (dst_addr),
    .rd_data     (rd_data),
    .bus_req     (bus_req),
    .cfg_open    (cfg_open),
    .aen         (aen),
    .addr        (addr),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .dack        (dack),
    .addr_step   (addr_step),
    .cnt_dec     (cnt_dec),
    .wr_data     (wr_data)
  );

  AST_GRANT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACQ && pend && bus_ack && !kill) |=> (aen && cfg_open == 1'b0)); // R5

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && pend && !kill) |=> bus_req); // R2

endmodule

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int CW  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0, sw_reset = 1'b0, compat_mode = 1'b0;
  logic [NCH-1:0] chan_req = '0, chan_mask = '0;
  logic [CW-1:0]  win_ch = '0;
  logic           cmd_m2m_en = 1'b0, act_m2m = 1'b0, io_to_mem = 1'b0;
  logic           bus_ack = 1'b0, eop_n = 1'b1, tc = 1'b0;
  logic [AW-1:0]  io_addr = 16'h1100, ch0_addr = 16'h2200, src_addr = 16'h3300, dst_addr = 16'h4400;
  logic [DW-1:0]  rd_data = 8'h00;

  logic           bus_req, cfg_open, aen, mem_rd_n, mem_wr_n, addr_step, cnt_dec;
  logic [AW-1:0]  addr;
  logic [NCH-1:0] dack;
  logic [DW-1:0]  wr_data;

  dma_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .compat_mode(compat_mode),
    .chan_req(chan_req), .chan_mask(chan_mask), .win_ch(win_ch),
    .cmd_m2m_en(cmd_m2m_en), .act_m2m(act_m2m), .io_to_mem(io_to_mem),
    .bus_ack(bus_ack), .eop_n(eop_n), .tc(tc), .io_addr(io_addr),
    .ch0_addr(ch0_addr), .src_addr(src_addr), .dst_addr(dst_addr), .rd_data(rd_data),
    .bus_req(bus_req), .cfg_open(cfg_open), .aen(aen), .addr(addr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .dack(dack),
    .addr_step(addr_step), .cnt_dec(cnt_dec), .wr_data(wr_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 waiting for bus, 2 I/O, 3 copy (step 1..8)
  int            ph = 0;
  int            mstep = 0;
  int            ach = 0;
  bit            eop_m = 1'b0;
  logic [DW-1:0] hold_m = '0;

  always @(posedge clk) begin : ref_model
    bit pend, pick, stop;
    pend = |(chan_req & ~chan_mask);
    pick = compat_mode ? (cmd_m2m_en && chan_req[0] && !chan_mask[0] && win_ch == 0) : act_m2m;
    if (!rst_n || (sw_reset && compat_mode)) begin
      ph = 0; mstep = 0; ach = 0; eop_m = 1'b0; hold_m = '0;
    end else begin
      case (ph)
        0: if (pend) ph = 1;
        1: if (!pend) ph = 0;
           else if (bus_ack) begin
             ach = int'(win_ch);
             if (pick) begin ph = 3; mstep = 1; end
             else ph = 2;
           end
        2: begin
             stop = tc || eop_m || !eop_n;
             ph = (pend && !stop) ? 1 : 0;
             eop_m = 1'b0;
           end
        default: begin
             if (mstep == 3) hold_m = rd_data;
             if (mstep == 8) begin
               stop = tc || eop_m || !eop_n;
               ph = (pend && !stop) ? 1 : 0;
               eop_m = 1'b0;
               mstep = 0;
             end else begin
               if (!eop_n) eop_m = 1'b1;
               mstep++;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin : compare
    string         tag;
    logic          e_req, e_open, e_aen, e_rd, e_wr, e_pulse;
    logic [AW-1:0] e_addr;
    logic [NCH-1:0] e_dack;
    if (!done) begin
      e_req = (ph != 0); e_open = (ph <= 1); e_aen = 1'b0; e_addr = '0;
      e_rd = 1'b1; e_wr = 1'b1; e_dack = '0; e_pulse = 1'b0; tag = "R1";
      if (ph == 1) tag = "R3";
      if (ph == 2) begin
        tag = "R6"; e_aen = 1'b1; e_addr = io_addr; e_dack = NCH'(1) << ach;
        e_wr = !io_to_mem; e_rd = io_to_mem; e_pulse = 1'b1;
      end
      if (ph == 3) begin
        e_aen = 1'b1;
        if (mstep <= 4) begin
          tag = "R7"; e_addr = compat_mode ? ch0_addr : src_addr;
          e_rd = !(mstep == 2 || mstep == 3);
        end else begin
          tag = "R8"; e_addr = dst_addr;
          e_wr = !(mstep == 6 || mstep == 7);
          e_pulse = (mstep == 8);
        end
      end
      chk("R2", "bus_req", 32'(bus_req), 32'(e_req));
      chk("R3", "cfg_open", 32'(cfg_open), 32'(e_open));
      chk(tag, "aen", 32'(aen), 32'(e_aen));
      chk(tag, "addr", 32'(addr), 32'(e_addr));
      chk(tag, "mem_rd_n", 32'(mem_rd_n), 32'(e_rd));
      chk(tag, "mem_wr_n", 32'(mem_wr_n), 32'(e_wr));
      chk(tag, "dack", 32'(dack), 32'(e_dack));
      chk(tag, "addr_step", 32'(addr_step), 32'(e_pulse));
      chk(tag, "cnt_dec", 32'(cnt_dec), 32'(e_pulse));
      chk("R8", "wr_data", 32'(wr_data), 32'(hold_m));
      chk("R12", "strobes apart", 32'(!mem_rd_n && !mem_wr_n), 32'd0);
    end
  end

  task automatic go_idle();
    chan_req = '0; chan_mask = '0; bus_ack = 1'b0; sw_reset = 1'b0;
    eop_n = 1'b1; tc = 1'b0; compat_mode = 1'b0; cmd_m2m_en = 1'b0; act_m2m = 1'b0;
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset bus_req", 32'(bus_req), 32'd0);
    chk("R1", "reset strobes", 32'({mem_rd_n, mem_wr_n}), 32'd3);
    chk("R1", "reset cfg_open", 32'(cfg_open), 32'd1);
    #1 rst_n = 1'b1;
    go_idle();

    // R2: masked request ignored
    chan_req = 4'b0010; chan_mask = 4'b0010;
    repeat (3) @(negedge clk);
    chk("R2", "masked stays idle", 32'(bus_req), 32'd0);
    go_idle();

    // R2/R3/R4: request then drop while waiting
    chan_req = 4'b0100;
    @(posedge clk); @(negedge clk);
    chk("R2", "bus_req after request", 32'(bus_req), 32'd1);
    chk("R3", "cfg_open while waiting", 32'(cfg_open), 32'd1);
    #1 chan_req = '0; bus_ack = 1'b1;
    @(negedge clk);
    chk("R4", "drop returns idle", 32'(bus_req), 32'd0);
    go_idle();

    // R5/R7: compatibility copy from channel 0
    compat_mode = 1'b1; cmd_m2m_en = 1'b1; chan_req = 4'b0001; win_ch = 2'd0; bus_ack = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5", "compat copy path no dack", 32'(dack), 32'd0);
    chk("R7", "compat source addr", 32'(addr), 32'(ch0_addr));
    go_idle();

    // R5/R6/R9: compatibility with non-zero winner takes I/O path; tc ends service
    compat_mode = 1'b1; cmd_m2m_en = 1'b1; chan_req = 4'b0011; win_ch = 2'd1;
    io_to_mem = 1'b1; bus_ack = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5", "I/O path dack", 32'(dack), 32'b0010);
    chk("R6", "I/O write strobe", 32'(mem_wr_n), 32'd0);
    #1 tc = 1'b1;
    @(negedge clk);
    chk("R9", "tc goes idle", 32'(bus_req), 32'd0);
    go_idle();

    // R10/R8: native copy with end-of-process held low runs all eight states
    act_m2m = 1'b1; chan_req = 4'b0100; win_ch = 2'd2; bus_ack = 1'b1;
    eop_n = 1'b0; rd_data = 8'hA5;
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R10", "copy state still running", 32'(aen), 32'd1);
      if (i == 5) begin
        chk("R8", "held byte in write", 32'(wr_data), 32'hA5);
        chk("R8", "write addr", 32'(addr), 32'(dst_addr));
      end
      @(negedge clk);
    end
    chk("R10", "idle after eighth state", 32'(bus_req), 32'd0);
    go_idle();

    // R11: soft reset ignored in native mode, honoured in compatibility mode
    act_m2m = 1'b1; chan_req = 4'b0100; bus_ack = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    #1 sw_reset = 1'b1;
    @(negedge clk);
    chk("R11", "native ignores soft reset", 32'(aen), 32'd1);
    #1 compat_mode = 1'b1;
    @(negedge clk);
    chk("R11", "compat soft reset idles", 32'(bus_req), 32'd0);
    chk("R11", "hold cleared", 32'(wr_data), 32'd0);
    go_idle();

    // mixed traffic, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      chan_req    = NCH'($urandom);
      chan_mask   = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
      win_ch      = CW'($urandom);
      compat_mode = (c / 500) % 2 == 1;
      cmd_m2m_en  = ($urandom % 2) == 0;
      act_m2m     = ($urandom % 2) == 0;
      io_to_mem   = ($urandom % 2) == 0;
      bus_ack     = ($urandom % 3) == 0;
      eop_n       = ($urandom % 12) != 0;
      tc          = ($urandom % 8) == 0;
      sw_reset    = ($urandom % 50) == 0;
      rd_data     = DW'($urandom);
      io_addr     = AW'($urandom);
      ch0_addr    = AW'($urandom);
      src_addr    = AW'($urandom);
      dst_addr    = AW'($urandom);
    end
    @(posedge clk); @(negedge clk);
    finish_run();
  end

endmodule